// File: doc/BRIEF.md
# Phase-Modulating Numerically Controlled Oscillator

This block turns a steady reference clock into a stream of digital sine samples, one sample per clock. A tuning word sets how far the running phase advances each cycle. The output frequency is therefore the tuning word times the clock rate divided by 2^32. A second word shifts the phase seen by the sine lookup without touching the running phase. This allows the carrier to be phase modulated. Rewriting the tuning word modulates the frequency.

Both control words are taken in on the clock through their own load strobes. A retune keeps the running phase, so the waveform has no jump. The top 12 bits of the offset-adjusted phase select a signed 12-bit amplitude. The amplitude comes from a sine table that is computed when the design is elaborated. Only a quarter of the wave is stored. The other three quarters come from mirroring it and negating it.

Top module: `nco_pm`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `sample` is 0 and `sample_vld` is 0. Reset clears the running phase, the tuning word and the offset word to zero.
- R2: `sample_vld` rises after the third rising edge following reset release and then stays high until the next reset.
- R3: On every clock the 32-bit running phase P gains the held tuning word and wraps modulo 2^32. The sample equals round(2047*sin(2*pi*a/4096)), where a = (P[31:20] + offset) mod 4096. Its range is -2047..2047.
- R4: A tuning word presented with `ftw_ld` high first affects the sample produced three rising edges after the edge that captures it.
- R5: An offset word (12 bits, 1 LSB = 1/4096 turn) presented with `pofs_ld` high shifts the sample three edges after its capture edge. It leaves the running phase untouched, so clearing the offset restores the unshifted waveform.
- R6: A retune does not reset or jump the running phase. After the change, the phase continues from its value at that point with the new step.
- R7: The first sample flagged valid after reset is the table entry for phase zero, which is 0.
- R8: While `ftw_ld` or `pofs_ld` is low, the value on `ftw` or `pofs` has no effect on the samples.
- R9: Samples taken half a turn apart are equal in magnitude and opposite in sign. An offset of 1024 with a zero tuning word gives +2047, 2048 gives 0, and 3072 gives -2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw_ld | input | 1 | Strobe that captures `ftw` |
| ftw | input | 32 | Frequency tuning word (phase step per clock) |
| pofs_ld | input | 1 | Strobe that captures `pofs` |
| pofs | input | 12 | Phase offset word, aligned to the top of the phase |
| sample | output | 12 | Signed sine amplitude |
| sample_vld | output | 1 | High once the pipeline holds real samples |

## Verification
The assertions assume that reset is held for at least one rising edge before it is released. The stimulus does this each time it resets the block. They also assume that the control inputs are known whenever their strobes are high. The stimulus drives every input from time zero and changes it only half a cycle away from the active edge. The assertions place no limit on how often the strobes fire. The stimulus therefore mixes single-cycle strobes, back-to-back retunes and long runs in which the data inputs change while the strobes stay low.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int PHASE_W = 32;
    localparam int ADDR_W  = 12;
    localparam int AMP_W   = 12;
    localparam int OFF_W   = 12;
    localparam int PIPE_LAT = 3;

    localparam real TWO_PI = 6.283185307179586;

    // Which quarter of the turn an address falls in.
    typedef enum logic [1:0] {
        QD_RISE     = 2'b00,
        QD_FALL     = 2'b01,
        QD_NEG_FALL = 2'b10,
        QD_NEG_RISE = 2'b11
    } quadrant_e;

    // Decoded lookup request for the quarter-wave table.
    typedef struct packed {
        logic mirror;
        logic negate;
    } fold_t;

    function automatic fold_t fold_of(input quadrant_e q);
        fold_t f;
        f.mirror = (q == QD_FALL) || (q == QD_NEG_RISE);
        f.negate = (q == QD_NEG_FALL) || (q == QD_NEG_RISE);
        return f;
    endfunction

    // Rounded magnitude of the sine for table index idx (first quarter only).
    function automatic int sine_mag(input int idx, input int addr_w, input int amp_w);
        real peak;
        real ang;
        peak = (2.0 ** (amp_w - 1)) - 1.0;
        ang  = TWO_PI * idx / (2.0 ** addr_w);
        return $rtoi(peak * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PHASE_W = nco_pkg::PHASE_W,
    parameter int ADDR_W  = nco_pkg::ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ftw_ld,
    input  logic [PHASE_W-1:0] ftw,
    output logic [ADDR_W-1:0]  phase_top
);

    logic [PHASE_W-1:0] step_q;
    logic [PHASE_W-1:0] acc_q;

    // The tuning word is held in its own register and the accumulator is never
    // reloaded, so a retune only changes the step size.
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            acc_q  <= '0;
        end else begin
            if (ftw_ld) begin
                step_q <= ftw;
            end
            acc_q <= acc_q + step_q;
        end
    end

    assign phase_top = acc_q[PHASE_W-1 -: ADDR_W];

endmodule

// File: rtl/nco_phase_offset.sv
module nco_phase_offset #(
    parameter int ADDR_W = nco_pkg::ADDR_W,
    parameter int OFF_W  = nco_pkg::OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pofs_ld,
    input  logic [OFF_W-1:0]  pofs,
    input  logic [ADDR_W-1:0] phase_top,
    output logic [ADDR_W-1:0] addr
);

    localparam int SHIFT = ADDR_W - OFF_W;

    logic [OFF_W-1:0]  ofs_q;
    logic [OFF_W-1:0]  ofs_d;
    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] addr_q;

    // Offset low bits are zero, so only the kept top bits need an adder.
    assign ofs_ext = ADDR_W'(ofs_d) << SHIFT;

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q  <= '0;
            ofs_d  <= '0;
            addr_q <= '0;
        end else begin
            if (pofs_ld) begin
                ofs_q <= pofs;
            end
            ofs_d  <= ofs_q;
            addr_q <= phase_top + ofs_ext;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
    parameter int ADDR_W = nco_pkg::ADDR_W,
    parameter int AMP_W  = nco_pkg::AMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [AMP_W-1:0]  sample
);
    import nco_pkg::*;

    localparam int FRAC_W = ADDR_W - 2;
    localparam int IDX_W  = ADDR_W - 1;
    localparam int QTR    = 1 << FRAC_W;

    logic [AMP_W-1:0] qtab [0:QTR];

    // Quarter-wave table, both end points included, computed at elaboration.
    for (genvar g = 0; g <= QTR; g++) begin : g_tab
        localparam logic [AMP_W-1:0] ENTRY = AMP_W'(sine_mag(g, ADDR_W, AMP_W));
        assign qtab[g] = ENTRY;
    end

    quadrant_e        quad;
    fold_t            fold;
    logic [FRAC_W-1:0] frac;
    logic [IDX_W-1:0]  idx;
    logic [AMP_W-1:0]  mag;
    logic [AMP_W-1:0]  amp_d;
    logic [AMP_W-1:0]  amp_q;

    always_comb begin
        quad  = quadrant_e'(addr[ADDR_W-1 -: 2]);
        fold  = fold_of(quad);
        frac  = addr[FRAC_W-1:0];
        idx   = fold.mirror ? (IDX_W'(QTR) - {1'b0, frac}) : {1'b0, frac};
        mag   = qtab[idx];
        amp_d = fold.negate ? (AMP_W'(0) - mag) : mag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_q <= '0;
        end else begin
            amp_q <= amp_d;
        end
    end

    assign sample = amp_q;

endmodule

// File: rtl/nco_pm.sv
module nco_pm #(
    parameter int PHASE_W = nco_pkg::PHASE_W,
    parameter int ADDR_W  = nco_pkg::ADDR_W,
    parameter int AMP_W   = nco_pkg::AMP_W,
    parameter int OFF_W   = nco_pkg::OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ftw_ld,
    input  logic [PHASE_W-1:0] ftw,
    input  logic               pofs_ld,
    input  logic [OFF_W-1:0]   pofs,
    output logic [AMP_W-1:0]   sample,
    output logic               sample_vld
);
    localparam int LAT = nco_pkg::PIPE_LAT;

    logic [ADDR_W-1:0] phase_top;
    logic [ADDR_W-1:0] addr;
    logic [LAT-1:0]    vld_sr;

    nco_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .ftw_ld    (ftw_ld),
        .ftw       (ftw),
        .phase_top (phase_top)
    );

    nco_phase_offset #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ofs (
        .clk       (clk),
        .rst       (rst),
        .pofs_ld   (pofs_ld),
        .pofs      (pofs),
        .phase_top (phase_top),
        .addr      (addr)
    );

    nco_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr),
        .sample (sample)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sr <= '0;
        end else begin
            vld_sr <= {vld_sr[LAT-2:0], 1'b1};
        end
    end

    assign sample_vld = vld_sr[LAT-1];

endmodule

// File: rtl/nco_pm_chk.sv
module nco_pm_chk #(
    parameter int AMP_W = nco_pkg::AMP_W
) (
    input logic             clk,
    input logic             rst,
    input logic [AMP_W-1:0] sample,
    input logic             sample_vld
);
    localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    // R1: pipeline comes out of reset empty
    p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sample == '0 && !sample_vld));

    // R2: valid never drops outside reset
    p_vld_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        sample_vld |=> sample_vld);

    // R3: amplitude stays symmetric, most negative code never produced
    p_amp_range_r3: assert property (@(posedge clk) disable iff (rst)
        sample_vld |-> (sample != MOST_NEG));

    // R7: first valid sample is phase zero
    p_first_zero_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_vld) |-> (sample == '0));

endmodule

bind nco_pm nco_pm_chk #(.AMP_W(AMP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample     (sample),
    .sample_vld (sample_vld)
);

// File: tb/tb_nco_pm.sv
module tb_nco_pm;
    localparam int CLK_NS = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ftw_ld = 1'b0;
    logic [31:0] ftw = '0;
    logic        pofs_ld = 1'b0;
    logic [11:0] pofs = '0;
    logic [11:0] sample;
    logic        sample_vld;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // behavioural expectation, built from the requirements
    logic [31:0] m_step, m_phase;
    logic [11:0] m_ofs1, m_ofs2, m_addr;
    int          m_amp;
    int          m_edges;

    always #(CLK_NS/2) clk = ~clk;

    nco_pm dut (
        .clk(clk), .rst(rst), .ftw_ld(ftw_ld), .ftw(ftw),
        .pofs_ld(pofs_ld), .pofs(pofs), .sample(sample), .sample_vld(sample_vld)
    );

    function automatic int ref_amp(input int a);
        real v;
        v = 2047.0 * $sin(6.283185307179586 * a / 4096.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic check(input string rq, input int act, input int exp, input int tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // One edge: update the expectation, then compare half a cycle later.
    task automatic tick();
        @(posedge clk);
        #1;
        if (rst) begin
            m_step = '0; m_phase = '0; m_ofs1 = '0; m_ofs2 = '0;
            m_addr = '0; m_amp = 0; m_edges = 0;
        end else begin
            m_amp   = ref_amp(int'(m_addr));
            m_addr  = m_phase[31:20] + m_ofs2;
            m_ofs2  = m_ofs1;
            if (pofs_ld) m_ofs1 = pofs;
            m_phase = m_phase + m_step;
            if (ftw_ld) m_step = ftw;
            m_edges++;
        end
        @(negedge clk);
        check({tag, " vld"}, int'(sample_vld), (m_edges >= 3) ? 1 : 0, 0);
        check({tag, " amp"}, int'($signed(sample)), (m_edges >= 3 || rst) ? m_amp : 0, 1);
    endtask

    task automatic do_reset();
        rst = 1'b1; ftw_ld = 1'b0; pofs_ld = 1'b0;
        tick(); tick();
        check("R1 reset amp", int'($signed(sample)), 0, 0);
        check("R1 reset vld", int'(sample_vld), 0, 0);
        rst = 1'b0;
    endtask

    task automatic load_ftw(input logic [31:0] w);
        ftw = w; ftw_ld = 1'b1;
        tick();
        ftw_ld = 1'b0; ftw = 32'hDEAD_BEEF;
    endtask

    task automatic load_ofs(input logic [11:0] w);
        pofs = w; pofs_ld = 1'b1;
        tick();
        pofs_ld = 1'b0; pofs = 12'hA5A;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 / R2 / R4 / R7: load quarter-turn step right at release
        tag = "R1";
        do_reset();
        tag = "R4";
        load_ftw(32'h4000_0000);
        tick();
        tick();
        check("R7 first valid is zero", int'($signed(sample)), 0, 0);
        check("R2 vld after three edges", int'(sample_vld), 1, 0);
        tick();
        check("R4 latency three", int'($signed(sample)), 2047, 0);
        tick();
        check("R3 half turn", int'($signed(sample)), 0, 0);
        tick();
        check("R3 three quarter", int'($signed(sample)), -2047, 0);
        tag = "R3";
        repeat (8) tick();

        // R5 / R9: pure offset with zero step
        tag = "R1";
        do_reset();
        tag = "R5";
        load_ofs(12'd1024);
        tick(); tick();
        check("R5 offset before latency", int'($signed(sample)), 0, 0);
        tick();
        check("R9 offset quarter", int'($signed(sample)), 2047, 0);
        load_ofs(12'd2048);
        tick(); tick(); tick();
        check("R9 offset half", int'($signed(sample)), 0, 0);
        load_ofs(12'd3072);
        tick(); tick(); tick();
        check("R9 offset three quarter", int'($signed(sample)), -2047, 0);
        load_ofs(12'd0);
        tick(); tick(); tick();
        check("R5 offset cleared", int'($signed(sample)), 0, 0);

        // R6: retunes mid-stream, including wrapping and negative steps
        tag = "R6";
        load_ftw(32'h0010_0000);
        repeat (40) tick();
        load_ftw(32'h0020_0000);
        load_ftw(32'h0123_4567);
        repeat (300) tick();
        load_ftw(32'hFFFF_FFFF);
        repeat (50) tick();
        load_ftw(32'h7FFF_FFFF);
        repeat (50) tick();
        load_ftw(32'hFFF0_0000);
        repeat (100) tick();

        // R8: data inputs change while strobes stay low
        tag = "R8";
        for (int i = 0; i < 200; i++) begin
            ftw  = 32'h1357_9BDF * i;
            pofs = 12'(i * 97);
            tick();
        end

        // R5 / R3: sweep every offset code on a slow carrier
        tag = "R5";
        load_ftw(32'h0010_0000);
        for (int k = 0; k < 4096; k++) begin
            pofs = 12'(k); pofs_ld = 1'b1;
            tick();
        end
        pofs_ld = 1'b0;

        // R3: sweep of tuning words over every table address
        tag = "R3";
        for (int s = 1; s < 16; s++) begin
            load_ftw(32'(s) * 32'h0011_1111);
            repeat (600) tick();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule